// File: doc/BRIEF.md
# Privileged-Mode Register Specifier Remapper

This block sits in the decode stage of an integer pipeline. For each instruction word presented with a valid strobe, it appends one context bit above the 32-bit word. That bit marks privileged mode and is taken from bit 0 of the instruction's program counter. The result is a 33-bit extended instruction.

The three 5-bit register specifiers are then translated into indices of a 40-entry physical integer space. That space holds the 32 architectural registers plus 8 shadow registers. In privileged mode, eight architectural registers are steered to the shadow bank; in normal mode every specifier passes through unchanged.

The block also raises a fault flag when a privileged-only major opcode arrives outside privileged mode. All results are registered and appear one clock after the strobe. The physical register file and the fault response live elsewhere.

Top module: `shadow_remap_top`

## Requirements
- R1: While `rst` is high and after its release, before any strobe, `out_valid`, `out_fault`, `out_ext` and all three physical indices read 0.
- R2: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: One cycle after a strobe, `out_ext[31:0]` equals the instruction word and `out_ext[32]` equals bit 0 of `in_pc`.
- R4: With `in_pc[0]` = 0, the physical indices equal the zero-extended specifier fields: A from word bits [25:21], B from bits [20:16] and C from bits [4:0].
- R5: With `in_pc[0]` = 1, a specifier value from 8 to 14 maps to physical index 32 to 38 respectively, and value 25 maps to 39.
- R6: With `in_pc[0]` = 1, every specifier value other than 8 to 14 and 25 maps to itself; in particular, register 31 is never redirected.
- R7: `out_fault` is 1 exactly when the strobed word's major opcode (bits [31:26]) is one of 0x19, 0x1B, 0x1D, 0x1E or 0x1F and `in_pc[0]` = 0. These opcodes never fault in privileged mode.
- R8: In a cycle following a cycle with `in_valid` low, `out_ext`, the three indices and `out_fault` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word strobe |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 64 | Program counter of the instruction; bit 0 is the privileged-mode flag |
| out_valid | output | 1 | Results valid |
| out_ext | output | 33 | Extended instruction: mode bit above the word |
| out_ra_phys | output | 6 | Physical index for specifier A |
| out_rb_phys | output | 6 | Physical index for specifier B |
| out_rc_phys | output | 6 | Physical index for specifier C |
| out_fault | output | 1 | Privileged-only opcode seen in normal mode |

## Verification
Every result is captured in a single output register stage, so each one is due at the first rising edge after the edge that samples the strobe. The bench drives inputs on the falling edge. It then waits through one rising edge and reads all outputs at the following falling edge, so each check looks at exactly one cycle of latency.

For the hold rule, the bench drops the strobe and changes the word and PC. It then reads the outputs after the next rising edge and expects the old values.

// File: rtl/shadow_remap_pkg.sv
package shadow_remap_pkg;

    localparam int INSN_W     = 32;
    localparam int ARCH_CNT   = 32;
    localparam int SHADOW_CNT = 8;
    localparam int SPEC_W     = $clog2(ARCH_CNT);
    localparam int PHYS_CNT   = ARCH_CNT + SHADOW_CNT;
    localparam int PHYS_W     = $clog2(PHYS_CNT);
    localparam int EXT_W      = INSN_W + 1;
    localparam int OPC_W      = 6;
    localparam int OPC_LSB    = INSN_W - OPC_W;

    // Specifier field positions
    localparam int FLD_A_LSB  = 21;
    localparam int FLD_B_LSB  = 16;
    localparam int FLD_C_LSB  = 0;

    // Shadowed architectural registers: a contiguous run plus one extra
    localparam int RUN_LO     = 8;
    localparam int RUN_HI     = 14;
    localparam int RUN_EXTRA  = 25;
    localparam int NEVER_MAP  = ARCH_CNT - 1;

    typedef logic [SPEC_W-1:0] arch_idx_t;
    typedef logic [PHYS_W-1:0] phys_idx_t;
    typedef logic [OPC_W-1:0]  opcode_t;

    typedef struct packed {
        logic              pal;
        logic [INSN_W-1:0] word;
    } ext_insn_t;

    typedef enum logic [1:0] {
        SPEC_A = 2'd0,
        SPEC_B = 2'd1,
        SPEC_C = 2'd2
    } spec_sel_e;

    typedef struct packed {
        phys_idx_t a;
        phys_idx_t b;
        phys_idx_t c;
    } phys_triple_t;

    function automatic arch_idx_t pick_field(ext_insn_t x, spec_sel_e s);
        case (s)
            SPEC_A:  return x.word[FLD_A_LSB +: SPEC_W];
            SPEC_B:  return x.word[FLD_B_LSB +: SPEC_W];
            default: return x.word[FLD_C_LSB +: SPEC_W];
        endcase
    endfunction

    function automatic phys_idx_t shadow_slot(arch_idx_t a);
        int v;
        v = int'(a);
        if (v == NEVER_MAP)
            return phys_idx_t'(v);
        if (v >= RUN_LO && v <= RUN_HI)
            return phys_idx_t'(ARCH_CNT + v - RUN_LO);
        if (v == RUN_EXTRA)
            return phys_idx_t'(ARCH_CNT + RUN_HI - RUN_LO + 1);
        return phys_idx_t'(v);
    endfunction

    function automatic logic is_priv_opcode(opcode_t op);
        case (op)
            6'h19, 6'h1B, 6'h1D, 6'h1E, 6'h1F: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sr_ctx_pack.sv
module sr_ctx_pack
    import shadow_remap_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic [INSN_W-1:0] insn,
    input  logic [PC_W-1:0]   pc,
    output ext_insn_t         ext
);
    logic unused_pc_hi;
    assign unused_pc_hi = ^pc[PC_W-1:1];

    always_comb begin
        ext.word = insn;
        ext.pal  = pc[0];
    end
endmodule

// File: rtl/sr_spec_redirect.sv
module sr_spec_redirect
    import shadow_remap_pkg::*;
#(
    parameter spec_sel_e SEL = SPEC_A
) (
    input  ext_insn_t ext,
    output phys_idx_t phys
);
    arch_idx_t arch;

    always_comb begin
        arch = pick_field(ext, SEL);
        if (ext.pal)
            phys = shadow_slot(arch);
        else
            phys = phys_idx_t'(arch);
    end

    // Shadow slots are only reachable in privileged mode
    always_comb begin
        if (!ext.pal)
            a_no_shadow_normal_r4: assert (int'(phys) < ARCH_CNT);
    end
endmodule

// File: rtl/sr_priv_check.sv
module sr_priv_check
    import shadow_remap_pkg::*;
(
    input  ext_insn_t ext,
    output logic      fault
);
    opcode_t op;

    always_comb begin
        op    = ext.word[OPC_LSB +: OPC_W];
        fault = is_priv_opcode(op) && !ext.pal;
    end
endmodule

// File: rtl/shadow_remap_top.sv
module shadow_remap_top
    import shadow_remap_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [PC_W-1:0]   in_pc,
    output logic              out_valid,
    output logic [EXT_W-1:0]  out_ext,
    output logic [PHYS_W-1:0] out_ra_phys,
    output logic [PHYS_W-1:0] out_rb_phys,
    output logic [PHYS_W-1:0] out_rc_phys,
    output logic              out_fault
);
    localparam int NUM_SPEC = 3;

    ext_insn_t    ext_c;
    phys_idx_t    phys_c [NUM_SPEC];
    logic         fault_c;

    ext_insn_t    ext_q;
    phys_triple_t phys_q;
    logic         fault_q;
    logic         valid_q;

    sr_ctx_pack #(.PC_W(PC_W)) u_ctx (
        .insn (in_insn),
        .pc   (in_pc),
        .ext  (ext_c)
    );

    for (genvar g = 0; g < NUM_SPEC; g++) begin : g_spec
        sr_spec_redirect #(.SEL(spec_sel_e'(g))) u_redir (
            .ext  (ext_c),
            .phys (phys_c[g])
        );
    end

    sr_priv_check u_priv (
        .ext   (ext_c),
        .fault (fault_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            ext_q   <= '0;
            phys_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                ext_q    <= ext_c;
                phys_q.a <= phys_c[0];
                phys_q.b <= phys_c[1];
                phys_q.c <= phys_c[2];
                fault_q  <= fault_c;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_ext     = ext_q;
    assign out_ra_phys = phys_q.a;
    assign out_rb_phys = phys_q.b;
    assign out_rc_phys = phys_q.c;
    assign out_fault   = fault_q;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_ext_capture_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_ext == $past({in_pc[0], in_insn}));

    p_normal_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_pc[0]) |=> out_rb_phys == PHYS_W'($past(in_insn[20:16])));

    p_extra_shadow_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pc[0] && in_insn[25:21] == 5'd25) |=> out_ra_phys == 6'd39);

    p_r31_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[4:0] == 5'd31) |=> out_rc_phys == 6'd31);

    p_no_fault_priv_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_pc[0]) |=> !out_fault);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_ext) && $stable(out_ra_phys) &&
                       $stable(out_rb_phys) && $stable(out_rc_phys) &&
                       $stable(out_fault)));
endmodule

// File: tb/shadow_remap_top_tb_top.sv
module shadow_remap_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_insn;
    logic [63:0] in_pc;
    logic        out_valid;
    logic [32:0] out_ext;
    logic [5:0]  out_ra_phys, out_rb_phys, out_rc_phys;
    logic        out_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shadow_remap_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_pc(in_pc), .out_valid(out_valid), .out_ext(out_ext),
        .out_ra_phys(out_ra_phys), .out_rb_phys(out_rb_phys),
        .out_rc_phys(out_rc_phys), .out_fault(out_fault)
    );

    function automatic int exp_phys(int r, bit pal);
        if (pal && r >= 8 && r <= 14) return 32 + (r - 8);
        if (pal && r == 25)           return 39;
        return r;
    endfunction

    function automatic bit exp_fault(int op, bit pal);
        return !pal && (op == 'h19 || op == 'h1B || op == 'h1D ||
                        op == 'h1E || op == 'h1F);
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Drive one strobe at a falling edge, sample at the next falling edge
    task automatic apply(logic [31:0] w, logic [63:0] pc);
        in_valid = 1'b1;
        in_insn  = w;
        in_pc    = pc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_insn  = '0;
        in_pc    = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", out_valid, 0);
        check("R1 ext", out_ext, 0);
        check("R1 ra", out_ra_phys, 0);
        check("R1 rc", out_rc_phys, 0);
        check("R1 fault", out_fault, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle valid", out_valid, 0);
        check("R1 idle rb", out_rb_phys, 0);

        // Register sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 32; r++) begin
                int rb = (r + 7) % 32;
                int rc = (r + 13) % 32;
                logic [31:0] w;
                logic [63:0] pc;
                w = {6'h10, 5'(r), 5'(rb), 11'h5A5, 5'(rc)};
                pc = {48'h0000_1234_5678, 12'(r * 4), 3'b000, 1'(m)};
                apply(w, pc);
                check("R2 valid", out_valid, 1);
                check("R3 ext", out_ext, {1'(m), w});
                check(m ? "R5/R6 ra" : "R4 ra", out_ra_phys, exp_phys(r, m));
                check(m ? "R5/R6 rb" : "R4 rb", out_rb_phys, exp_phys(rb, m));
                check(m ? "R5/R6 rc" : "R4 rc", out_rc_phys, exp_phys(rc, m));
                check("R7 fault", out_fault, 0);
            end
        end

        // Opcode sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int op = 0; op < 64; op++) begin
                logic [31:0] w;
                w = {6'(op), 5'd31, 5'd9, 11'h0, 5'd25};
                apply(w, {60'h0ABC, 3'b100, 1'(m)});
                check("R7 fault", out_fault, exp_fault(op, m));
                check("R6 r31", out_ra_phys, 31);
            end
        end

        // Hold: a faulting, shadowed word, then idle with changed inputs
        apply({6'h19, 5'd8, 5'd14, 11'h0, 5'd25}, 64'h0);
        check("R7 fault set", out_fault, 1);
        in_insn = {6'h10, 5'd1, 5'd2, 11'h0, 5'd3};
        in_pc   = 64'h1;
        @(negedge clk);
        check("R2 low", out_valid, 0);
        check("R8 ext", out_ext, {1'b0, 6'h19, 5'd8, 5'd14, 11'h0, 5'd25});
        check("R8 ra", out_ra_phys, 8);
        check("R8 rb", out_rb_phys, 14);
        check("R8 rc", out_rc_phys, 25);
        check("R8 fault", out_fault, 1);

        // Privileged mode with the same word: no fault, shadow mapping
        apply({6'h19, 5'd8, 5'd14, 11'h0, 5'd25}, 64'h1);
        check("R7 priv", out_fault, 0);
        check("R5 ra", out_ra_phys, 32);
        check("R5 rb", out_rb_phys, 38);
        check("R5 rc", out_rc_phys, 39);

        // Back-to-back strobes
        in_valid = 1'b1;
        in_insn  = {6'h10, 5'd12, 5'd0, 11'h0, 5'd31};
        in_pc    = 64'h3;
        @(negedge clk);
        check("R5 b2b ra", out_ra_phys, 36);
        in_insn  = {6'h10, 5'd12, 5'd0, 11'h0, 5'd31};
        in_pc    = 64'h2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 b2b valid", out_valid, 1);
        check("R4 b2b ra", out_ra_phys, 12);
        check("R3 b2b pal", out_ext[32], 0);

        finish_run();
    end
endmodule